// File: doc/BRIEF.md
# Per-Source Pending/Queued Event Gate

This block sits between a set of interrupt sources and an event router. For every source it keeps a two-bit state: a pending bit P (an event has been sent and its end of interrupt has not yet arrived) and a queued bit Q (another event arrived while one was pending). An event from a source reaches the router only when that source is ready. Events that arrive while the source is pending are merged into a single queued event, and a source that is switched off drops its events. Message-type sources raise an event on every cycle their input is high. Level-type sources raise an event on a rising edge of their input, and they are checked again at end of interrupt.

Software manages each source through a single management port. The operation code selects one of: a trigger store, an end-of-interrupt load, a plain state read, or one of four load-and-set operations that return the old state and write a new one. Loads answer one cycle later on `rdValid`/`rdData`. Forwarded events leave on `fwdValid`/`fwdSrc`, at most one per cycle, and the lowest-numbered source goes first when several are waiting.

Top module: `pq_event_gate`

## Requirements
- R1: After reset every source is in state 01 (off), `fwdValid` is 0 and `rdValid` is 0.
- R2: The state is encoded with P in bit 1 and Q in bit 0. Operation 010 (read) returns the current state on `rdData` with `rdValid` high one cycle later, and leaves the state unchanged.
- R3: A trigger (input pulse, or operation 000) on a source in state 00 moves it to 10 and forwards exactly one event carrying that source number.
- R4: A trigger on a source in state 10 or 11 moves it to 11 and forwards nothing.
- R5: A trigger on a source in state 01 is ignored: no event is forwarded and the state stays 01.
- R6: End of interrupt (operation 001) on a source with Q clear (message type, or level type with its input low) moves it to 00, returns 00 and forwards nothing.
- R7: End of interrupt on a source with Q set moves it to 10, forwards one event and returns 01.
- R8: Operations 100, 101, 110 and 111 return the old state and set the state to the operation's low two bits, without forwarding.
- R9: A level-type source (selected by the `LEVEL_MASK` parameter, default sources 12 to 15) triggers only on a rising edge of its input. Holding the input high does not trigger again.
- R10: End of interrupt on a level-type source with Q clear and its input still high moves it to 10, forwards one event and returns 01.
- R11: When several events become ready in the same cycle, they are issued on consecutive cycles, lowest source number first.
- R12: Operation 011 is reserved. It changes no state, produces no response and forwards nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | NUM_SRC | Per-source trigger pulses (message) or levels (level) |
| mgmtValid | input | 1 | Management operation valid this cycle |
| mgmtOp | input | 3 | Management operation code |
| mgmtSrc | input | SRC_W | Source addressed by the operation |
| rdValid | output | 1 | Load response valid |
| rdData | output | 2 | Load response: old state, or 1 when end of interrupt re-forwarded |
| fwdValid | output | 1 | Forwarded event valid |
| fwdSrc | output | SRC_W | Source number of the forwarded event |

## Verification
The hardest situation to reach is a level-type source that is still asserted when its end of interrupt arrives. The edge detector has already used up the rising edge, so the re-forward can only come from the end-of-interrupt path. The stimulus arms the source, raises the level and holds it for several cycles to show that it fires only once, then issues the end of interrupt with the level still high, then lowers the level and issues another. Simultaneous arrival is reached by pulsing three armed sources on the same cycle and logging the order of the events that leave.

// File: rtl/pqgate_pkg.sv
package pqgate_pkg;

  typedef logic [1:0] pq_t;

  localparam pq_t PQ_RDY  = 2'b00;
  localparam pq_t PQ_OFF  = 2'b01;
  localparam pq_t PQ_PEND = 2'b10;
  localparam pq_t PQ_QUED = 2'b11;

  localparam logic [2:0] OP_TRIG = 3'b000;
  localparam logic [2:0] OP_EOI  = 3'b001;
  localparam logic [2:0] OP_READ = 3'b010;

  typedef struct packed {
    logic trig;
    logic eoi;
    logic rd;
    logic set;
    pq_t  setVal;
  } mgmt_strb_t;

  typedef struct packed {
    pq_t  nxt;
    logic fwd;
  } step_t;

  // Effect of one trigger on a state
  function automatic step_t trigStep(pq_t cur);
    step_t s;
    case (cur)
      PQ_RDY:           s = '{nxt: PQ_PEND, fwd: 1'b1};
      PQ_PEND, PQ_QUED: s = '{nxt: PQ_QUED, fwd: 1'b0};
      default:          s = '{nxt: cur,     fwd: 1'b0};
    endcase
    return s;
  endfunction

  // Effect of end of interrupt; fwd doubles as the load answer
  function automatic step_t eoiStep(pq_t cur, logic lvlSrc, logic lvlHigh);
    step_t s;
    if (cur[0])               s = '{nxt: PQ_PEND, fwd: 1'b1};
    else if (lvlSrc && lvlHigh) s = '{nxt: PQ_PEND, fwd: 1'b1};
    else                      s = '{nxt: PQ_RDY,  fwd: 1'b0};
    return s;
  endfunction

endpackage

// File: rtl/pq_mgmt_ctrl.sv
module pq_mgmt_ctrl
  import pqgate_pkg::*;
#(
  parameter int SRC_W = 4
) (
  input  logic             mgmtValid,
  input  logic [2:0]       mgmtOp,
  input  logic [SRC_W-1:0] mgmtSrc,
  output mgmt_strb_t       strb,
  output logic [SRC_W-1:0] tgtSrc
);

  assign tgtSrc = mgmtSrc;

  always_comb begin
    strb = '0;
    if (mgmtValid) begin
      if (mgmtOp[2]) begin
        strb.set    = 1'b1;
        strb.setVal = mgmtOp[1:0];
      end else begin
        case (mgmtOp)
          OP_TRIG: strb.trig = 1'b1;
          OP_EOI:  strb.eoi  = 1'b1;
          OP_READ: strb.rd   = 1'b1;
          default: strb      = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/pq_state_dp.sv
module pq_state_dp
  import pqgate_pkg::*;
#(
  parameter int                  NUM_SRC    = 16,
  parameter int                  SRC_W      = 4,
  parameter logic [NUM_SRC-1:0]  LEVEL_MASK = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  mgmt_strb_t         strb,
  input  logic [SRC_W-1:0]   tgtSrc,
  output logic               rdValid,
  output logic [1:0]         rdData,
  output logic               fwdValid,
  output logic [SRC_W-1:0]   fwdSrc
);

  pq_t                pqQ    [NUM_SRC];
  pq_t                pqNext [NUM_SRC];
  logic [NUM_SRC-1:0] newFwd;
  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] grant;
  logic [SRC_W-1:0]   pickIdx;
  logic               rdValidQ;
  logic [1:0]         rdDataQ;

  // Per-source next state: management op first, then the hardware trigger
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic  touch;
    logic  hwTrig;
    step_t mStep;
    step_t hStep;

    assign touch = (tgtSrc == SRC_W'(i)) && (strb.trig || strb.eoi || strb.set);

    if (LEVEL_MASK[i]) begin : g_level
      logic prevQ;
      always_ff @(posedge clk) begin
        if (!rstN) prevQ <= 1'b0;
        else       prevQ <= srcIn[i];
      end
      assign hwTrig = srcIn[i] && !prevQ;
    end else begin : g_msg
      assign hwTrig = srcIn[i];
    end

    always_comb begin
      mStep = '{nxt: pqQ[i], fwd: 1'b0};
      if (touch) begin
        if (strb.trig)     mStep = trigStep(pqQ[i]);
        else if (strb.eoi) mStep = eoiStep(pqQ[i], LEVEL_MASK[i], srcIn[i]);
        else               mStep = '{nxt: strb.setVal, fwd: 1'b0};
      end
    end

    always_comb begin
      if (hwTrig) hStep = trigStep(mStep.nxt);
      else        hStep = '{nxt: mStep.nxt, fwd: 1'b0};
    end

    assign pqNext[i] = hStep.nxt;
    assign newFwd[i] = mStep.fwd || hStep.fwd;

    // R4
    // pending bit survives hardware triggers when no management op touches it
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pqQ[i][1] && !touch) |=> pqQ[i][1]);

    // R5
    // an off source stays off unless management rewrites it
    off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pqQ[i] == PQ_OFF && !touch) |=> pqQ[i] == PQ_OFF);
  end

  // Load response path
  pq_t  oldPq;
  logic eoiRet;
  assign oldPq  = pqQ[tgtSrc];
  assign eoiRet = eoiStep(oldPq, LEVEL_MASK[tgtSrc], srcIn[tgtSrc]).fwd;

  // Lowest-index pick among waiting events
  always_comb begin
    grant   = '0;
    pickIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendQ[i]) begin
        grant   = '0;
        grant[i] = 1'b1;
        pickIdx = SRC_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) pqQ[i] <= PQ_OFF;
      pendQ    <= '0;
      rdValidQ <= 1'b0;
      rdDataQ  <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) pqQ[i] <= pqNext[i];
      pendQ    <= (pendQ & ~grant) | newFwd;
      rdValidQ <= strb.eoi || strb.rd || strb.set;
      rdDataQ  <= strb.eoi ? {1'b0, eoiRet} : oldPq;
    end
  end

  assign rdValid  = rdValidQ;
  assign rdData   = rdDataQ;
  assign fwdValid = |pendQ;
  assign fwdSrc   = pickIdx;

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pendQ == '0) && !rdValidQ);

  // R2
  read_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rd |=> rdValid);

  // R7
  eoi_requeue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoi && oldPq == PQ_QUED) |=> rdValid && rdData == 2'b01 && pendQ[$past(tgtSrc)]);

  // R11
  grant_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !newFwd[fwdSrc]) |=> !pendQ[$past(fwdSrc)]);

endmodule

// File: rtl/pq_event_gate.sv
module pq_event_gate
  import pqgate_pkg::*;
#(
  parameter int                 NUM_SRC    = 16,
  parameter int                 SRC_W      = $clog2(NUM_SRC),
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 16'hF000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               mgmtValid,
  input  logic [2:0]         mgmtOp,
  input  logic [SRC_W-1:0]   mgmtSrc,
  output logic               rdValid,
  output logic [1:0]         rdData,
  output logic               fwdValid,
  output logic [SRC_W-1:0]   fwdSrc
);

  mgmt_strb_t       strb;
  logic [SRC_W-1:0] tgtSrc;

  pq_mgmt_ctrl #(.SRC_W(SRC_W)) u_ctrl (
    .mgmtValid (mgmtValid),
    .mgmtOp    (mgmtOp),
    .mgmtSrc   (mgmtSrc),
    .strb      (strb),
    .tgtSrc    (tgtSrc)
  );

  pq_state_dp #(
    .NUM_SRC    (NUM_SRC),
    .SRC_W      (SRC_W),
    .LEVEL_MASK (LEVEL_MASK)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .srcIn    (srcIn),
    .strb     (strb),
    .tgtSrc   (tgtSrc),
    .rdValid  (rdValid),
    .rdData   (rdData),
    .fwdValid (fwdValid),
    .fwdSrc   (fwdSrc)
  );

  // R12
  resv_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mgmtValid && mgmtOp == 3'b011) |=> !rdValid);

endmodule

// File: tb/tb_pq_event_gate.sv
`timescale 1ns/1ps
module tb_pq_event_gate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] srcIn = '0;
  logic        mgmtValid = 1'b0;
  logic [2:0]  mgmtOp = '0;
  logic [3:0]  mgmtSrc = '0;
  logic        rdValid;
  logic [1:0]  rdData;
  logic        fwdValid;
  logic [3:0]  fwdSrc;

  int total = 0;
  int fails = 0;
  int fwdCnt [16];
  int logSrc [8];
  int logN = 0;

  always #2.5 clk = ~clk;

  pq_event_gate dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn),
    .mgmtValid(mgmtValid), .mgmtOp(mgmtOp), .mgmtSrc(mgmtSrc),
    .rdValid(rdValid), .rdData(rdData),
    .fwdValid(fwdValid), .fwdSrc(fwdSrc)
  );

  initial for (int i = 0; i < 16; i++) fwdCnt[i] = 0;

  always @(negedge clk) begin
    if (rstN && fwdValid) begin
      fwdCnt[fwdSrc] = fwdCnt[fwdSrc] + 1;
      if (logN < 8) logSrc[logN] = int'(fwdSrc);
      logN = logN + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic mop(input logic [2:0] op, input logic [3:0] s,
                     output logic [1:0] d, output logic v);
    mgmtValid = 1'b1; mgmtOp = op; mgmtSrc = s;
    step();
    mgmtValid = 1'b0;
    d = rdData; v = rdValid;
  endtask

  task automatic readChk(input string req, input logic [3:0] s, input int exp);
    logic [1:0] d; logic v;
    mop(3'b010, s, d, v);
    chk({req, " rdValid"}, v, 1);
    chk({req, " state"}, d, exp);
  endtask

  task automatic pulse(input logic [3:0] s);
    srcIn[s] = 1'b1;
    step();
    srcIn[s] = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 fwdValid", fwdValid, 0);
    chk("R1 rdValid", rdValid, 0);
    readChk("R1 src0", 4'd0, 1);
    readChk("R1 src15", 4'd15, 1);
    readChk("R2 read twice src7", 4'd7, 1);
    readChk("R2 read twice src7 again", 4'd7, 1);
  endtask

  task automatic testTrigAndCoalesce();
    logic [1:0] d; logic v; int c0;
    mop(3'b100, 4'd2, d, v);
    chk("R8 set00 old", d, 1);
    c0 = fwdCnt[2];
    pulse(4'd2);
    chk("R3 one forward", fwdCnt[2] - c0, 1);
    readChk("R3 state", 4'd2, 2);
    pulse(4'd2); step(); pulse(4'd2); step();
    chk("R4 no extra forward", fwdCnt[2] - c0, 1);
    readChk("R4 state queued", 4'd2, 3);
    mop(3'b001, 4'd2, d, v);
    chk("R7 eoi answer", d, 1);
    chk("R7 re-forward", fwdCnt[2] - c0, 2);
    readChk("R7 state", 4'd2, 2);
    mop(3'b001, 4'd2, d, v);
    chk("R6 eoi answer", d, 0);
    chk("R6 no forward", fwdCnt[2] - c0, 2);
    readChk("R6 state", 4'd2, 0);
    mop(3'b000, 4'd2, d, v);
    chk("R3 mgmt trigger forward", fwdCnt[2] - c0, 3);
  endtask

  task automatic testOffAndSet();
    logic [1:0] d; logic v; int c0;
    mop(3'b100, 4'd6, d, v);
    mop(3'b101, 4'd6, d, v);
    chk("R8 set01 old", d, 0);
    c0 = fwdCnt[6];
    pulse(4'd6); step();
    chk("R5 no forward when off", fwdCnt[6] - c0, 0);
    readChk("R5 state stays off", 4'd6, 1);
    mop(3'b111, 4'd6, d, v);
    chk("R8 set11 old", d, 1);
    mop(3'b110, 4'd6, d, v);
    chk("R8 set10 old", d, 3);
    step();
    chk("R8 set no forward", fwdCnt[6] - c0, 0);
    readChk("R8 state", 4'd6, 2);
  endtask

  task automatic testLevel();
    logic [1:0] d; logic v; int c0;
    mop(3'b100, 4'd13, d, v);
    c0 = fwdCnt[13];
    srcIn[13] = 1'b1;
    step(); step(); step();
    chk("R9 single edge forward", fwdCnt[13] - c0, 1);
    readChk("R9 state", 4'd13, 2);
    mop(3'b001, 4'd13, d, v);
    chk("R10 eoi answer high", d, 1);
    chk("R10 re-forward", fwdCnt[13] - c0, 2);
    readChk("R10 state", 4'd13, 2);
    srcIn[13] = 1'b0;
    step();
    mop(3'b001, 4'd13, d, v);
    chk("R6 level low eoi answer", d, 0);
    readChk("R6 level low state", 4'd13, 0);
    chk("R10 no forward when low", fwdCnt[13] - c0, 2);
  endtask

  task automatic testOrder();
    logic [1:0] d; logic v;
    mop(3'b100, 4'd9, d, v);
    mop(3'b100, 4'd1, d, v);
    mop(3'b100, 4'd5, d, v);
    step();
    logN = 0;
    srcIn[9] = 1'b1; srcIn[5] = 1'b1; srcIn[1] = 1'b1;
    step();
    srcIn = '0;
    step(); step(); step();
    chk("R11 count", logN, 3);
    chk("R11 first", logSrc[0], 1);
    chk("R11 second", logSrc[1], 5);
    chk("R11 third", logSrc[2], 9);
  endtask

  task automatic testReserved();
    logic [1:0] d; logic v; int c0;
    mop(3'b110, 4'd4, d, v);
    c0 = fwdCnt[4];
    mop(3'b011, 4'd4, d, v);
    chk("R12 no response", v, 0);
    chk("R12 no forward", fwdCnt[4] - c0, 0);
    readChk("R12 state kept", 4'd4, 2);
  endtask

  initial begin
    #1000000;
    total++; fails++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    step(); step(); step();
    rstN = 1'b1;
    step();
    testReset();
    testTrigAndCoalesce();
    testOffAndSet();
    testLevel();
    testOrder();
    testReserved();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule